// File: doc/BRIEF.md
# Multi-Block Erase Address Collector

This block sits behind the command decoder of a flash memory controller. Once the decoder accepts a block-erase confirm, it pulses `start` in the clock cycle in which that confirming write strobe falls. The collector treats the address present in that cycle as the first block to erase. From then on, every further falling edge of the active-low write strobe loads one more block address. Each load sets one flag in a per-block flag vector.

Loads must keep arriving within a window measured from the rising edge of the previous strobe. The window is a clock-cycle count set by a parameter. When the strobe stays high for the whole window, loading closes and the block pulses `launch`. The erase engine then takes the flag vector, which stays stable until the next `start`.

The block supports two block maps:

- **Plain map.** The three top address bits pick one of eight equal blocks.
- **Mixed map.** Seven large blocks are picked by the three top address bits. The topmost large region is split into four small blocks, which the next two address bits pick.

An abort received while loading discards everything collected and launches nothing.

Top module: `blk_erase_collector`

## Requirements
- R1: After reset `flags` is all zeros, and both `loading` and `launch` are low.
- R2: A `start` pulse while not loading clears the previous flags and sets the flag for the address present in that cycle. `loading` is high from the next cycle. A `start` pulse while loading has no effect.
- R3: While loading, each falling edge of `wr_n` (high at one clock edge, low at the next) sets the flag for the address present at that edge. Loading the same block again leaves a single flag for it.
- R4: With `map_sel`=0 (plain map), the flag index is `addr[16:14]` (0 to 7), and flags 8 to 10 stay 0.
- R5: With `map_sel`=1 (mixed map), the flag index is `addr[16:14]` when that field is below 7. When the field equals 7, the index is 7 + `addr[13:12]` (7 to 10).
- R6: The map is taken from `map_sel` in the `start` cycle. Changing `map_sel` while loading has no effect on the loads that follow.
- R7: The window counts clock edges at which `wr_n` is high, starting from zero at its last rise. A fall seen on the TIMEOUT_CYCLES-th such edge still loads. If `wr_n` is still high at that edge, loading ends. While `wr_n` is held low the window never expires.
- R8: When the window expires, `launch` is high for exactly one cycle, starting in the cycle after the expiring edge. `loading` falls in that same cycle. The flags then hold, unaffected by strobes, until the next `start`.
- R9: `abort` high while loading clears all flags and drops `loading` from the next cycle, and no `launch` follows.
- R10: `abort` while not loading has no effect on `flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Erase-confirm accepted; the address in this cycle is the first load |
| map_sel | input | 1 | Block map: 0 plain (8 blocks), 1 mixed (11 blocks) |
| wr_n | input | 1 | Write strobe, active low, sampled on the clock |
| addr | input | ADDR_W (17) | Byte address from the bus |
| abort | input | 1 | Discard the collected set and return to idle |
| flags | output | 11 | Per-block erase flags handed to the erase engine |
| launch | output | 1 | One-cycle pulse: loading closed, erase may begin |
| loading | output | 1 | Collection window open |

## Verification
The directed cases are chosen to separate the two maps:

- Addresses inside the top large region land on four distinct flags in the mixed map, but on one flag in the plain map.
- Duplicate addresses within one block check that repeated loads leave a single flag.
- Gaps of exactly one cycle under the limit, and strobes held low far longer than the window, tell an off-by-one window count apart from a correct one.
- Abort and start pulses sent while loading and while idle check that each acts only in the state where it should.

Random sequences mix the map, the address, the number of loads and the gap lengths. Each run is checked against an address-range model of the flag index and the exact launch cycle.

// File: rtl/blk_erase_pkg.sv
package blk_erase_pkg;

  localparam int unsigned HI_W       = 3;
  localparam int unsigned SUB_W      = 2;
  localparam int unsigned NUM_WIDE   = (1 << HI_W) - 1;
  localparam int unsigned NUM_NARROW = 1 << SUB_W;
  localparam int unsigned FLAG_W     = NUM_WIDE + NUM_NARROW;
  localparam int unsigned NUM_PLAIN  = 1 << HI_W;

  typedef enum logic {
    MAP_PLAIN = 1'b0,
    MAP_MIXED = 1'b1
  } map_e;

  typedef logic [FLAG_W-1:0] flag_vec_t;

  function automatic int unsigned flag_index(input map_e m,
                                             input logic [HI_W-1:0] hi,
                                             input logic [SUB_W-1:0] sub);
    if (m == MAP_MIXED && hi == '1) begin
      return NUM_WIDE + int'(sub);
    end
    return int'(hi);
  endfunction

  function automatic flag_vec_t flag_onehot(input map_e m,
                                            input logic [HI_W-1:0] hi,
                                            input logic [SUB_W-1:0] sub);
    flag_vec_t v;
    v = '0;
    v[flag_index(m, hi, sub)] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/bec_strobe_edge.sv
module bec_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall,
  output logic rise,
  output logic high
);

  logic prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n <= 1'b1;
    end else begin
      prev_n <= strobe_n;
    end
  end

  assign fall = prev_n & ~strobe_n;
  assign rise = ~prev_n & strobe_n;
  assign high = strobe_n;

endmodule

// File: rtl/bec_window_timer.sv
module bec_window_timer #(
  parameter int unsigned LIMIT = 1500000,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             strobe_high,
  output logic             expire,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = run & strobe_high & (cnt_q == LAST);
  assign count  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || !strobe_high || expire) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/bec_flag_bank.sv
module bec_flag_bank
  import blk_erase_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      ld,
  input  flag_vec_t sel,
  output flag_vec_t flags
);

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= 1'b0;
      end else begin
        f_q <= (f_q & ~clr) | (ld & sel[i]);
      end
    end
    assign flags[i] = f_q;
  end

endmodule

// File: rtl/blk_erase_collector.sv
module blk_erase_collector
  import blk_erase_pkg::*;
#(
  parameter int unsigned ADDR_W         = 17,
  parameter int unsigned TIMEOUT_CYCLES = 1500000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    map_sel,
  input  logic                    wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    abort,
  output logic [FLAG_W-1:0]       flags,
  output logic                    launch,
  output logic                    loading
);

  localparam int unsigned HI_LSB  = ADDR_W - HI_W;
  localparam int unsigned SUB_LSB = HI_LSB - SUB_W;
  localparam int unsigned CNT_W   = $clog2(TIMEOUT_CYCLES + 1);

  logic             loading_q, launch_q;
  map_e             map_q, map_use;
  logic             fall_evt, rise_evt, strobe_hi;
  logic             start_evt, load_evt, abort_evt, expire_evt, timer_exp;
  logic [CNT_W-1:0] win_cnt;
  flag_vec_t        sel_vec, flag_q;

  bec_strobe_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (wr_n),
    .fall     (fall_evt),
    .rise     (rise_evt),
    .high     (strobe_hi)
  );

  bec_window_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (loading_q),
    .strobe_high (strobe_hi),
    .expire      (timer_exp),
    .count       (win_cnt)
  );

  assign start_evt  = start & ~loading_q;
  assign abort_evt  = abort & loading_q;
  assign load_evt   = loading_q & fall_evt & ~abort;
  assign expire_evt = timer_exp & ~abort;

  assign map_use = start_evt ? map_e'(map_sel) : map_q;
  assign sel_vec = flag_onehot(map_use, addr[ADDR_W-1:HI_LSB], addr[HI_LSB-1:SUB_LSB]);

  bec_flag_bank u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_evt | abort_evt),
    .ld    (start_evt | load_evt),
    .sel   (sel_vec),
    .flags (flag_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading_q <= 1'b0;
      launch_q  <= 1'b0;
      map_q     <= MAP_PLAIN;
    end else begin
      launch_q <= expire_evt;
      if (start_evt) begin
        loading_q <= 1'b1;
        map_q     <= map_e'(map_sel);
      end else if (abort_evt || expire_evt) begin
        loading_q <= 1'b0;
      end
    end
  end

  assign flags   = flag_q;
  assign launch  = launch_q;
  assign loading = loading_q;

endmodule

// File: rtl/bec_checker.sv
module bec_checker #(
  parameter int unsigned FLAG_W = 11,
  parameter int unsigned CNT_W  = 21,
  parameter int unsigned LIMIT  = 1500000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              abort,
  input logic              wr_n,
  input logic              loading,
  input logic              launch,
  input logic [FLAG_W-1:0] flags,
  input logic              expire_evt,
  input logic [CNT_W-1:0]  win_cnt
);

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !loading) |=> (loading && $countones(flags) == 1)); // R2

  AST_FLAGS_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && !abort) |=> ((flags & $past(flags)) == $past(flags))); // R3

  AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch); // R8

  AST_LAUNCH_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (!loading && flags != '0)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!loading && !start) |=> $stable(flags)); // R10

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && abort) |=> (flags == '0 && !loading && !launch)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= CNT_W'(LIMIT - 1)); // R7

  AST_LOW_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !expire_evt); // R7

endmodule

bind blk_erase_collector bec_checker #(
  .FLAG_W (blk_erase_pkg::FLAG_W),
  .CNT_W  (CNT_W),
  .LIMIT  (TIMEOUT_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .abort      (abort),
  .wr_n       (wr_n),
  .loading    (loading),
  .launch     (launch),
  .flags      (flags),
  .expire_evt (expire_evt),
  .win_cnt    (win_cnt)
);

// File: tb/blk_erase_collector_bench.sv
`timescale 1ns/1ps
module blk_erase_collector_bench;

  localparam int T = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        map_sel = 1'b0;
  logic        wr_n = 1'b1;
  logic [16:0] addr = '0;
  logic        abort = 1'b0;
  logic [10:0] flags;
  logic        launch, loading;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  blk_erase_collector #(.ADDR_W(17), .TIMEOUT_CYCLES(T)) u_blk_erase_collector (
    .clk(clk), .rst_n(rst_n), .start(start), .map_sel(map_sel), .wr_n(wr_n),
    .addr(addr), .abort(abort), .flags(flags), .launch(launch), .loading(loading)
  );

  function automatic int ref_index(input bit mixed, input logic [16:0] a);
    if (mixed && a >= 17'h1C000) return 7 + int'((a - 17'h1C000) >> 12);
    return int'(a >> 14);
  endfunction

  function automatic logic [10:0] ref_bit(input bit mixed, input logic [16:0] a);
    return 11'(1) << ref_index(mixed, a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input bit mixed, input logic [16:0] a);
    @(negedge clk);
    start = 1'b1; map_sel = mixed; addr = a; wr_n = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic raise_after(input int low);
    repeat (low - 1) @(negedge clk);
    wr_n = 1'b1;
  endtask

  task automatic do_load(input logic [16:0] a, input int gap, input int low);
    repeat (gap) @(negedge clk);
    addr = a; wr_n = 1'b0;
    repeat (low) @(negedge clk);
    wr_n = 1'b1;
  endtask

  task automatic wait_launch(output int first, output int count);
    first = 0; count = 0;
    for (int i = 1; i <= T + 4; i++) begin
      @(negedge clk);
      if (launch) begin
        count++;
        if (first == 0) first = i;
      end
    end
  endtask

  initial begin
    #(20ns * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int first, cnt;
    logic [10:0] exp_f, held;

    repeat (3) @(negedge clk);
    chk(flags == 0 && !loading && !launch, "R1 reset state", {flags, loading, launch}, 0);
    rst_n = 1'b1;

    // Plain map, duplicate block, boundary gap of T-1
    do_start(1'b0, 17'h04000);
    chk(loading == 1'b1, "R2 loading after start", loading, 1);
    chk(flags == 11'h002, "R2 first load", flags, 11'h002);
    raise_after(2);
    do_load(17'h1C000, 3, 1);
    do_load(17'h05123, T - 1, 2);
    chk(flags == 11'h082, "R3 duplicate keeps one flag, R4 plain top region", flags, 11'h082);
    wait_launch(first, cnt);
    chk(first == T, "R7 launch cycle", first, T);
    chk(cnt == 1, "R8 launch single pulse", cnt, 1);
    chk(!loading, "R8 loading low after launch", loading, 0);
    chk(flags == 11'h082, "R4 plain flags at launch", flags, 11'h082);
    held = flags;
    // Strobe and abort while idle
    do_load(17'h08000, 1, 2);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    @(negedge clk);
    chk(flags == held, "R10 abort idle / R8 strobe idle", flags, held);

    // Mixed map, map_sel flipped during loading
    do_start(1'b1, 17'h1D000);
    chk(flags == 11'h100, "R2 start clears old flags, R5 small block", flags, 11'h100);
    map_sel = 1'b0;
    raise_after(1);
    do_load(17'h1F800, 2, 1);
    do_load(17'h1C000, 4, 3);
    do_load(17'h18000, 1, 1);
    do_load(17'h00010, 5, 1);
    exp_f = 11'h100 | 11'h400 | 11'h080 | 11'h040 | 11'h001;
    wait_launch(first, cnt);
    chk(flags == exp_f, "R5 mixed map / R6 map_sel ignored", flags, exp_f);
    chk(first == T && cnt == 1, "R8 launch mixed", first, T);

    // Strobe held low far beyond the window
    do_start(1'b0, 17'h10000);
    repeat (3 * T) @(negedge clk);
    chk(loading == 1'b1, "R7 no expiry while low", loading, 1);
    wr_n = 1'b1;
    wait_launch(first, cnt);
    chk(first == T, "R7 launch after long low", first, T);

    // Start while loading ignored
    do_start(1'b0, 17'h00000);
    raise_after(1);
    repeat (2) @(negedge clk);
    start = 1'b1; addr = 17'h1C000;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(flags == 11'h001 && loading, "R2 start while loading ignored", flags, 11'h001);
    // Abort while loading
    do_load(17'h0C000, 1, 1);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk(flags == 0 && !loading, "R9 abort clears", {flags, loading}, 0);
    wait_launch(first, cnt);
    chk(cnt == 0, "R9 no launch after abort", cnt, 0);

    // Random runs
    void'($urandom(32'd1234));
    for (int it = 0; it < 40; it++) begin
      bit mx;
      int nl;
      logic [16:0] a;
      mx = 1'($urandom_range(0, 1));
      a = 17'($urandom);
      do_start(mx, a);
      exp_f = ref_bit(mx, a);
      map_sel = 1'($urandom_range(0, 1));
      raise_after(int'($urandom_range(1, 3)));
      nl = int'($urandom_range(0, 4));
      for (int k = 0; k < nl; k++) begin
        a = 17'($urandom);
        do_load(a, int'($urandom_range(1, T - 1)), int'($urandom_range(1, 3)));
        exp_f |= ref_bit(mx, a);
      end
      wait_launch(first, cnt);
      chk(flags == exp_f, mx ? "R5 random mixed flags" : "R4 random plain flags", flags, exp_f);
      chk(first == T && cnt == 1, "R7 random launch timing", first, T);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule